// File: doc/BRIEF.md
# Static RAM Address Mapper with Boot Overlay

This block places a 24-bit processor byte address onto two external static RAM banks, each 512K words of 16 bits with its own chip enable and its own upper and lower byte-lane enables. Three windows are decoded. Chip RAM is 512 Kbyte at 0x000000. Fast RAM is 1 Mbyte at 0xC00000. A 256 Kbyte system image area sits at 0xF80000 and is backed by ordinary RAM. Any other address reaches no memory, completes normally and reads as zero. The read-data output is zero whenever it is not carrying a result, so it can be ORed onto a shared bus.

After reset, the image area accepts writes so that a loader can fill it. A pulse on `load_done` write-protects it. From then on, a write to that window completes but reaches no RAM. Also after reset, a small external boot ROM answers reads in the lowest `BOOT_BYTES` of the map. A pulse on `loader_rst` takes this overlay away, and address 0 then reads chip RAM. Only the block's own reset re-arms either flag.

Each request takes one access cycle followed by one acknowledge cycle. The write strobe is gated by a copy of the clock delayed by a quarter period. It therefore opens and closes while address, data and enables are stable.

Top module: `sram_mapper`

## Requirements
- R1: Addresses 0x000000–0x07FFFF select bank 0 (chip enable index 0) with SRAM word address equal to CPU address bits 18:1.
- R2: Addresses 0xC00000–0xCFFFFF select bank 1 (chip enable index 1) with SRAM word address equal to CPU address bits 19:1.
- R3: Addresses 0xF80000–0xFBFFFF select bank 0 with SRAM word address bit 18 set, bit 17 clear and bits 16:0 equal to CPU address bits 17:1.
- R4: During an access, only the selected bank's byte lanes are enabled. The upper-lane enable follows `cpu_ub` and the lower-lane enable follows `cpu_lb`. All enables of the other bank stay high (inactive).
- R5: After reset, writes to the image window reach the RAM. After a `load_done` pulse, such a write drives no chip enable, no output enable and no write strobe, still acknowledges, and leaves the stored data unchanged.
- R6: While the overlay is active, reads below `BOOT_BYTES` assert `boot_rd` and return `boot_data`, with `boot_addr` equal to CPU address bits 9:1 and no SRAM enable. Writes in that window go to chip RAM as in R1.
- R7: After a `loader_rst` pulse, reads below `BOOT_BYTES` go to chip RAM as in R1.
- R8: An address outside all windows asserts no SRAM or boot enable, acknowledges, and reads as zero.
- R9: `cpu_ack` is high for exactly one cycle, in the second cycle after the cycle in which `cpu_req` is sampled. `cpu_rdata` is zero whenever `cpu_ack` is low, and it is zero for a write.
- R10: `sram_we_n` is low only during the access cycle of a permitted write while `qclk` is high. `sram_oe_n` is low only for SRAM reads.
- R11: During and right after reset, all chip enables, `sram_we_n` and `sram_oe_n` are high and `cpu_ack` and `boot_rd` are low. Reset re-enables image writes and the overlay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| qclk | input | 1 | Main clock delayed by a quarter period |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request pulse, sampled when idle |
| cpu_addr | input | 23 | CPU byte address bits 23:1 |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_ub | input | 1 | Upper byte lane requested |
| cpu_lb | input | 1 | Lower byte lane requested |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, zero when not acknowledging |
| cpu_ack | output | 1 | One-cycle completion pulse |
| load_done | input | 1 | Pulse: write-protect the image window |
| loader_rst | input | 1 | Pulse: remove the boot overlay |
| boot_rd | output | 1 | Boot ROM read enable |
| boot_addr | output | 9 | Boot ROM word address |
| boot_data | input | 16 | Boot ROM read data |
| sram_addr | output | 19 | SRAM word address, shared by both banks |
| sram_ce_n | output | 2 | Per-bank chip enables, active low |
| sram_ub_n | output | 2 | Per-bank upper byte enables, active low |
| sram_lb_n | output | 2 | Per-bank lower byte enables, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_wdata | output | 16 | Data toward SRAM |
| sram_rdata | input | 16 | Data from SRAM |

## Verification
The bench probes the first and last word of every window and the addresses just outside each one. A decoder with an off-by-one tag or a wrong bank bit would then either alias two regions or drop the edge words. A write to the protected image area is followed by a read-back. A design that only blocked the write strobe, or ignored `load_done`, would either show the chip enable or return the new value. The overlay tests cover three cases: its last word, the first chip word past it, and a write beneath it. The overlay is then removed and reset re-arms both flags. A design that let the overlay capture writes, or that cleared a flag on the wrong event, would return boot data or stale data where RAM contents are expected.

// File: rtl/sram_map_pkg.sv
package sram_map_pkg;

    localparam int CPU_AW   = 24;
    localparam int DW       = 16;
    localparam int SRAM_AW  = 19;
    localparam int NBANK    = 2;
    localparam int PHYS_AW  = SRAM_AW + $clog2(NBANK);
    localparam int BANK_BIT = SRAM_AW;

    // window tags compared against the top address bits
    localparam logic [4:0] CHIP_TAG = 5'b00000;   // bits 23:19
    localparam logic [3:0] FAST_TAG = 4'hC;       // bits 23:20
    localparam logic [5:0] ROM_TAG  = 6'b111110;  // bits 23:18

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CHIP,
        RG_FAST,
        RG_ROM,
        RG_BOOT
    } region_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ACC,
        SQ_DONE
    } seq_t;

    typedef struct packed {
        region_t              rg;
        logic [PHYS_AW-1:0]   paddr;
    } map_t;

    typedef struct packed {
        map_t                 map;
        logic                 wr;
        logic                 ub;
        logic                 lb;
        logic [DW-1:0]        wdata;
    } req_t;

    function automatic logic is_sram(region_t r);
        return (r == RG_CHIP) || (r == RG_FAST) || (r == RG_ROM);
    endfunction

    // physical word address: bit 19 picks the bank
    function automatic logic [PHYS_AW-1:0] phys_of(region_t r, logic [CPU_AW-1:1] a);
        logic [PHYS_AW-1:0] p;
        case (r)
            RG_CHIP: p = {2'b00, a[18:1]};
            RG_FAST: p = {1'b1, a[19:1]};
            RG_ROM:  p = {3'b010, a[17:1]};
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_region_decode.sv
module sram_region_decode
    import sram_map_pkg::*;
#(
    parameter int BOOT_WAW = 9
) (
    input  logic [CPU_AW-1:1]   addr,
    input  logic                wr,
    input  logic                overlay_on,
    input  logic                rom_open,
    output map_t                map,
    output logic [BOOT_WAW-1:0] boot_waddr
);

    region_t rg;

    always_comb begin
        rg = RG_NONE;
        if (overlay_on && !wr && (addr[CPU_AW-1:BOOT_WAW+1] == '0)) begin
            rg = RG_BOOT;
        end else if (addr[CPU_AW-1:CPU_AW-5] == CHIP_TAG) begin
            rg = RG_CHIP;
        end else if (addr[CPU_AW-1:CPU_AW-4] == FAST_TAG) begin
            rg = RG_FAST;
        end else if (addr[CPU_AW-1:CPU_AW-6] == ROM_TAG) begin
            // a protected image write is turned into a miss
            rg = (wr && !rom_open) ? RG_NONE : RG_ROM;
        end
        map.rg    = rg;
        map.paddr = phys_of(rg, addr);
    end

    assign boot_waddr = addr[BOOT_WAW:1];

endmodule

// File: rtl/sram_boot_flags.sv
module sram_boot_flags (
    input  logic clk,
    input  logic rst,
    input  logic load_done,
    input  logic loader_rst,
    output logic rom_open,
    output logic overlay_on
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_open   <= 1'b1;
            overlay_on <= 1'b1;
        end else begin
            if (load_done)  rom_open   <= 1'b0;
            if (loader_rst) overlay_on <= 1'b0;
        end
    end

endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
    import sram_map_pkg::*;
#(
    parameter int BOOT_WAW = 9
) (
    input  logic                 clk,
    input  logic                 qclk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  req_t                 req_in,
    input  logic [BOOT_WAW-1:0]  boot_waddr_in,
    input  logic [DW-1:0]        sram_rdata,
    input  logic [DW-1:0]        boot_data,
    output logic [DW-1:0]        cpu_rdata,
    output logic                 cpu_ack,
    output logic                 boot_rd,
    output logic [BOOT_WAW-1:0]  boot_addr,
    output logic [SRAM_AW-1:0]   sram_addr,
    output logic [NBANK-1:0]     sram_ce_n,
    output logic [NBANK-1:0]     sram_ub_n,
    output logic [NBANK-1:0]     sram_lb_n,
    output logic                 sram_we_n,
    output logic                 sram_oe_n,
    output logic [DW-1:0]        sram_wdata
);

    seq_t                st;
    req_t                cur;
    logic [BOOT_WAW-1:0] boot_q;
    logic [DW-1:0]       rdata_q;
    logic                in_acc;
    logic                hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cur     <= '0;
            boot_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        cur    <= req_in;
                        boot_q <= boot_waddr_in;
                        st     <= SQ_ACC;
                    end
                end
                SQ_ACC: begin
                    if (cur.wr)                    rdata_q <= '0;
                    else if (is_sram(cur.map.rg))  rdata_q <= sram_rdata;
                    else if (cur.map.rg == RG_BOOT) rdata_q <= boot_data;
                    else                           rdata_q <= '0;
                    st <= SQ_DONE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign in_acc = (st == SQ_ACC);
    assign hit    = in_acc && is_sram(cur.map.rg);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel;
        assign sel          = hit && (cur.map.paddr[PHYS_AW-1:BANK_BIT] == ($clog2(NBANK))'(b));
        assign sram_ce_n[b] = !sel;
        assign sram_ub_n[b] = !(sel && cur.ub);
        assign sram_lb_n[b] = !(sel && cur.lb);
    end

    assign sram_addr  = hit ? cur.map.paddr[SRAM_AW-1:0] : '0;
    assign sram_oe_n  = !(hit && !cur.wr);
    assign sram_we_n  = !(hit && cur.wr && qclk);
    assign sram_wdata = (hit && cur.wr) ? cur.wdata : '0;

    assign boot_rd    = in_acc && (cur.map.rg == RG_BOOT);
    assign boot_addr  = boot_rd ? boot_q : '0;

    assign cpu_ack    = (st == SQ_DONE);
    assign cpu_rdata  = cpu_ack ? rdata_q : '0;

endmodule

// File: rtl/sram_mapper.sv
module sram_mapper
    import sram_map_pkg::*;
#(
    parameter int BOOT_BYTES = 1024,
    localparam int BOOT_WAW  = $clog2(BOOT_BYTES) - 1
) (
    input  logic                 clk,
    input  logic                 qclk,
    input  logic                 rst,
    input  logic                 cpu_req,
    input  logic [CPU_AW-1:1]    cpu_addr,
    input  logic                 cpu_wr,
    input  logic                 cpu_ub,
    input  logic                 cpu_lb,
    input  logic [DW-1:0]        cpu_wdata,
    output logic [DW-1:0]        cpu_rdata,
    output logic                 cpu_ack,
    input  logic                 load_done,
    input  logic                 loader_rst,
    output logic                 boot_rd,
    output logic [BOOT_WAW-1:0]  boot_addr,
    input  logic [DW-1:0]        boot_data,
    output logic [SRAM_AW-1:0]   sram_addr,
    output logic [NBANK-1:0]     sram_ce_n,
    output logic [NBANK-1:0]     sram_ub_n,
    output logic [NBANK-1:0]     sram_lb_n,
    output logic                 sram_we_n,
    output logic                 sram_oe_n,
    output logic [DW-1:0]        sram_wdata,
    input  logic [DW-1:0]        sram_rdata
);

    logic                rom_open;
    logic                overlay_on;
    map_t                dec_map;
    logic [BOOT_WAW-1:0] dec_boot;
    req_t                req;

    sram_boot_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .load_done  (load_done),
        .loader_rst (loader_rst),
        .rom_open   (rom_open),
        .overlay_on (overlay_on)
    );

    sram_region_decode #(.BOOT_WAW(BOOT_WAW)) u_dec (
        .addr       (cpu_addr),
        .wr         (cpu_wr),
        .overlay_on (overlay_on),
        .rom_open   (rom_open),
        .map        (dec_map),
        .boot_waddr (dec_boot)
    );

    always_comb begin
        req.map   = dec_map;
        req.wr    = cpu_wr;
        req.ub    = cpu_ub;
        req.lb    = cpu_lb;
        req.wdata = cpu_wdata;
    end

    sram_access_seq #(.BOOT_WAW(BOOT_WAW)) u_seq (
        .clk           (clk),
        .qclk          (qclk),
        .rst           (rst),
        .req_valid     (cpu_req),
        .req_in        (req),
        .boot_waddr_in (dec_boot),
        .sram_rdata    (sram_rdata),
        .boot_data     (boot_data),
        .cpu_rdata     (cpu_rdata),
        .cpu_ack       (cpu_ack),
        .boot_rd       (boot_rd),
        .boot_addr     (boot_addr),
        .sram_addr     (sram_addr),
        .sram_ce_n     (sram_ce_n),
        .sram_ub_n     (sram_ub_n),
        .sram_lb_n     (sram_lb_n),
        .sram_we_n     (sram_we_n),
        .sram_oe_n     (sram_oe_n),
        .sram_wdata    (sram_wdata)
    );

endmodule

// File: rtl/sram_mapper_chk.sv
module sram_mapper_chk (
    input logic        clk,
    input logic        qclk,
    input logic        rst,
    input logic [15:0] cpu_rdata,
    input logic        cpu_ack,
    input logic        boot_rd,
    input logic [1:0]  sram_ce_n,
    input logic [1:0]  sram_ub_n,
    input logic [1:0]  sram_lb_n,
    input logic        sram_we_n,
    input logic        sram_oe_n,
    input logic        rom_open,
    input logic        overlay_on
);

    a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !cpu_ack |-> (cpu_rdata == 16'h0));

    a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    a_r1_one_bank: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sram_ce_n));

    a_r4_lanes_need_ce: assert property (@(posedge clk) disable iff (rst)
        (((~sram_ub_n) | (~sram_lb_n)) & (~sram_ce_n)) == ((~sram_ub_n) | (~sram_lb_n)));

    a_r6_boot_excludes_sram: assert property (@(posedge clk) disable iff (rst)
        boot_rd |-> (sram_ce_n == 2'b11) && sram_oe_n);

    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        !rom_open |=> !rom_open);

    a_r7_overlay_sticky: assert property (@(posedge clk) disable iff (rst)
        !overlay_on |=> !overlay_on);

    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sram_ce_n == 2'b11) && sram_we_n && sram_oe_n && !cpu_ack);

    always_comb begin
        if (rst == 1'b0 && sram_we_n == 1'b0) begin
            a_r10_we_in_qphase: assert (qclk == 1'b1);
        end
    end

endmodule

bind sram_mapper sram_mapper_chk u_chk (
    .clk        (clk),
    .qclk       (qclk),
    .rst        (rst),
    .cpu_rdata  (cpu_rdata),
    .cpu_ack    (cpu_ack),
    .boot_rd    (boot_rd),
    .sram_ce_n  (sram_ce_n),
    .sram_ub_n  (sram_ub_n),
    .sram_lb_n  (sram_lb_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .rom_open   (rom_open),
    .overlay_on (overlay_on)
);

// File: tb/sim_sram_mapper.sv
module sim_sram_mapper;

    logic        clk = 1'b0;
    logic        qclk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic [23:1] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_ub = 1'b0;
    logic        cpu_lb = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ack;
    logic        load_done = 1'b0;
    logic        loader_rst = 1'b0;
    logic        boot_rd;
    logic [8:0]  boot_addr;
    logic [15:0] boot_data;
    logic [18:0] sram_addr;
    logic [1:0]  sram_ce_n, sram_ub_n, sram_lb_n;
    logic        sram_we_n, sram_oe_n;
    logic [15:0] sram_wdata;
    logic [15:0] sram_rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] mem[int];

    always #2 clk = ~clk;
    always @(clk) qclk <= #1 clk;

    sram_mapper u0 (
        .clk(clk), .qclk(qclk), .rst(rst),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_ub(cpu_ub), .cpu_lb(cpu_lb), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .load_done(load_done), .loader_rst(loader_rst),
        .boot_rd(boot_rd), .boot_addr(boot_addr), .boot_data(boot_data),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ub_n(sram_ub_n),
        .sram_lb_n(sram_lb_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    // boot ROM model
    assign boot_data = 16'hB000 | {7'd0, boot_addr};

    // two-bank SRAM model: write at the rising end of the strobe
    always @(posedge sram_we_n) begin
        for (int b = 0; b < 2; b++) begin
            if (sram_ce_n[b] == 1'b0) begin
                int k;
                logic [15:0] v;
                k = int'({b[0], sram_addr});
                v = mem.exists(k) ? mem[k] : 16'hDEAD;
                if (sram_ub_n[b] == 1'b0) v[15:8] = sram_wdata[15:8];
                if (sram_lb_n[b] == 1'b0) v[7:0]  = sram_wdata[7:0];
                mem[k] = v;
            end
        end
    end

    always @(sram_ce_n or sram_oe_n or sram_addr) begin
        sram_rdata = 16'h0;
        for (int b = 0; b < 2; b++) begin
            if (sram_ce_n[b] == 1'b0 && sram_oe_n == 1'b0) begin
                int k;
                k = int'({b[0], sram_addr});
                sram_rdata = mem.exists(k) ? mem[k] : 16'hDEAD;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // kind: 0 bank0, 1 bank1, 2 no target, 3 boot ROM
    task automatic access(input logic [23:0] a, input bit wr, input bit ub, input bit lb,
                          input logic [15:0] wd, input int kind, input logic [18:0] wa,
                          input logic [15:0] exp_rd, input string tag);
        @(negedge clk);
        cpu_addr  = a[23:1];
        cpu_wr    = wr;
        cpu_ub    = ub;
        cpu_lb    = lb;
        cpu_wdata = wd;
        cpu_req   = 1'b1;
        exp_q.push_back(wr ? 16'h0 : exp_rd);
        tag_q.push_back(tag);
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_ack == 1'b0, {tag, " R9 no early ack"}, cpu_ack, 0);
        if (kind == 0 || kind == 1) begin
            logic [1:0] ce_e, ub_e, lb_e;
            ce_e = 2'b11; ub_e = 2'b11; lb_e = 2'b11;
            ce_e[kind] = 1'b0;
            ub_e[kind] = !ub;
            lb_e[kind] = !lb;
            chk(sram_ce_n == ce_e, {tag, " ce"}, sram_ce_n, ce_e);
            chk(sram_addr == wa, {tag, " addr"}, sram_addr, wa);
            chk({sram_ub_n, sram_lb_n} == {ub_e, lb_e}, {tag, " R4 lanes"},
                {sram_ub_n, sram_lb_n}, {ub_e, lb_e});
            chk({sram_oe_n, sram_we_n} == {wr, !wr}, {tag, " R10 strobes"},
                {sram_oe_n, sram_we_n}, {wr, !wr});
            if (wr) chk(sram_wdata == wd, {tag, " wdata"}, sram_wdata, wd);
        end else if (kind == 2) begin
            chk(sram_ce_n == 2'b11 && sram_we_n && sram_oe_n && !boot_rd, {tag, " no target"},
                {sram_ce_n, sram_we_n, sram_oe_n, boot_rd}, 5'b11110);
        end else begin
            chk(sram_ce_n == 2'b11 && boot_rd && boot_addr == wa[8:0], {tag, " boot select"},
                {sram_ce_n, boot_rd, boot_addr}, {2'b11, 1'b1, wa[8:0]});
        end
        @(negedge clk);
        chk(cpu_ack == 1'b1, {tag, " R9 ack timing"}, cpu_ack, 1);
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected ack", 1, 0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cpu_rdata == e, {t, " rdata"}, cpu_rdata, e);
                end
            end else if (cpu_rdata != 16'h0) begin
                chk(1'b0, "R9 idle bus not zero", cpu_rdata, 0);
            end
        end
    end

    task automatic pulse_load_done();
        @(negedge clk); load_done = 1'b1;
        @(negedge clk); load_done = 1'b0;
    endtask

    task automatic pulse_loader_rst();
        @(negedge clk); loader_rst = 1'b1;
        @(negedge clk); loader_rst = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(sram_ce_n == 2'b11 && sram_we_n && sram_oe_n && !cpu_ack && !boot_rd && cpu_rdata == 0,
            "R11 reset quiet", {sram_ce_n, sram_we_n, sram_oe_n, cpu_ack, boot_rd}, 6'b111100);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        do_reset();
        // R1 chip RAM
        access(24'h001234, 1, 1, 1, 16'hA1B2, 0, 19'h0091A, 16'h0, "R1 chip write");
        access(24'h001234, 0, 1, 1, 16'h0,    0, 19'h0091A, 16'hA1B2, "R1 chip read");
        access(24'h07FFFE, 1, 1, 1, 16'h0C0C, 0, 19'h3FFFF, 16'h0, "R1 chip top write");
        access(24'h07FFFE, 0, 1, 1, 16'h0,    0, 19'h3FFFF, 16'h0C0C, "R1 chip top read");
        // R4 byte lanes
        access(24'h001234, 1, 1, 0, 16'hFFFF, 0, 19'h0091A, 16'h0, "R4 upper lane write");
        access(24'h001234, 1, 0, 1, 16'h0033, 0, 19'h0091A, 16'h0, "R4 lower lane write");
        access(24'h001234, 0, 1, 1, 16'h0,    0, 19'h0091A, 16'hFF33, "R4 lane read");
        // R2 fast RAM
        access(24'hC81000, 1, 1, 1, 16'h5A5A, 1, 19'h40800, 16'h0, "R2 fast write");
        access(24'hC81000, 0, 1, 1, 16'h0,    1, 19'h40800, 16'h5A5A, "R2 fast read");
        access(24'hC00000, 1, 1, 1, 16'h1357, 1, 19'h00000, 16'h0, "R2 fast base write");
        access(24'hCFFFFE, 1, 1, 1, 16'h2468, 1, 19'h7FFFF, 16'h0, "R2 fast top write");
        access(24'hC00000, 0, 1, 1, 16'h0,    1, 19'h00000, 16'h1357, "R2 fast base read");
        access(24'hCFFFFE, 0, 1, 1, 16'h0,    1, 19'h7FFFF, 16'h2468, "R2 fast top read");
        // R3 image window, still writable (R5)
        access(24'hF80000, 1, 1, 1, 16'h1111, 0, 19'h40000, 16'h0, "R3 image base write");
        access(24'hFBFFFE, 1, 1, 1, 16'h9999, 0, 19'h5FFFF, 16'h0, "R3 image top write");
        access(24'hF80000, 0, 1, 1, 16'h0,    0, 19'h40000, 16'h1111, "R3 image base read");
        access(24'hFBFFFE, 0, 1, 1, 16'h0,    0, 19'h5FFFF, 16'h9999, "R3 image top read");
        // R8 outside all windows
        access(24'h080000, 0, 1, 1, 16'h0,    2, 19'h0, 16'h0, "R8 past chip read");
        access(24'hD00000, 1, 1, 1, 16'hEEEE, 2, 19'h0, 16'h0, "R8 past fast write");
        access(24'hF7FFFE, 0, 1, 1, 16'h0,    2, 19'h0, 16'h0, "R8 below image read");
        access(24'hFC0000, 0, 1, 1, 16'h0,    2, 19'h0, 16'h0, "R8 past image read");
        // R6 boot overlay
        access(24'h000010, 0, 1, 1, 16'h0,    3, 19'h00008, 16'hB008, "R6 overlay read");
        access(24'h0003FE, 0, 1, 1, 16'h0,    3, 19'h001FF, 16'hB1FF, "R6 overlay last word");
        access(24'h000400, 1, 1, 1, 16'h4444, 0, 19'h00200, 16'h0, "R6 past overlay write");
        access(24'h000400, 0, 1, 1, 16'h0,    0, 19'h00200, 16'h4444, "R6 past overlay read");
        access(24'h000010, 1, 1, 1, 16'h7777, 0, 19'h00008, 16'h0, "R6 write under overlay");
        // R5 write protection
        pulse_load_done();
        access(24'hF80000, 1, 1, 1, 16'h2222, 2, 19'h0, 16'h0, "R5 locked write");
        access(24'hF80000, 0, 1, 1, 16'h0,    0, 19'h40000, 16'h1111, "R5 locked data kept");
        access(24'h000010, 0, 1, 1, 16'h0,    3, 19'h00008, 16'hB008, "R6 overlay kept after lock");
        // R7 overlay removal
        pulse_loader_rst();
        access(24'h000010, 0, 1, 1, 16'h0,    0, 19'h00008, 16'h7777, "R7 chip after overlay");
        access(24'hFBFFFE, 1, 1, 1, 16'h3333, 2, 19'h0, 16'h0, "R5 still locked");
        // R11 reset re-arms both flags
        do_reset();
        access(24'h000010, 0, 1, 1, 16'h0,    3, 19'h00008, 16'hB008, "R11 overlay rearmed");
        access(24'hF80000, 1, 1, 1, 16'h5555, 0, 19'h40000, 16'h0, "R11 image writable");
        access(24'hF80000, 0, 1, 1, 16'h0,    0, 19'h40000, 16'h5555, "R11 image read");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all acks seen", exp_q.size(), 0);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired (R9 no completion) actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule